// File: doc/BRIEF.md
# CAN Controller Status Flag Unit

This unit keeps the three status flags of a CAN protocol controller up to date, and it also produces the transmit-acknowledge pulse. The three flags are transmission-idle, error-warning and bus-off. The unit reads the transmit and receive error counters, which are kept elsewhere. It also takes single-cycle strobes from the bit-level protocol engine. These strobes mark:

- the 7th end-of-frame bit and the 3rd intermission bit;
- arbitration loss, bus idle, reception start and transmission start;
- a transmit error, halt entry, a software reset and bus-off recovery.

Every output is registered. Each one changes on the clock edge that follows the strobe or counter value that causes the change.

A five-state machine follows transmission. The states are `S_IDLE`, `S_XMIT` (frame in progress), `S_XERR` (an error or overload flag after a transmit error), `S_XDONE` (own frame finished, waiting for intermission) and `S_BOFF` (bus-off).

The transitions are checked in priority order:

1. Software reset goes from any state to `S_IDLE`.
2. Bus-off entry goes from any state to `S_BOFF`.
3. A release strobe (arbitration loss, bus idle, reception start, halt) goes from `S_XMIT`, `S_XERR` or `S_XDONE` to `S_IDLE`.
4. Below those, the remaining moves are:
   - `S_IDLE`→`S_XMIT` on transmission start.
   - `S_XMIT`→`S_XERR` on a transmit error.
   - `S_XMIT`→`S_XDONE` on the 7th end-of-frame bit.
   - `S_XERR`/`S_XDONE`→`S_XMIT` on transmission start, or on the 3rd intermission bit with a message pending.
   - `S_XERR`/`S_XDONE`→`S_IDLE` on the 3rd intermission bit with nothing pending.
   - `S_BOFF`→`S_IDLE` on recovery.

The transmission-idle flag is 1 exactly when the next state is `S_IDLE`.

Top module: `can_status_flags`

## Requirements
- R1: `busoff_o` goes to 1 on the edge after `tec_i` is 256 or more. It then stays 1 even if `tec_i` falls, until it is cleared.
- R2: `busoff_o` is 0 after hardware reset. It is cleared on the edge after `bo_recover_i` or `sw_reset_i`, and a clear wins over a count of 256 or more in the same cycle.
- R3: `warn_o` is 1 when either counter is in 96..255. It is 0 when both counters are below 96.
- R4: `warn_o` is 0 whenever `busoff_o` is 1, even while `rec_i` is at 96 or more.
- R5: `txidle_o` is 1 after hardware reset. It is 0 whenever `busoff_o` is 1.
- R6: A `tx_start_i` strobe while idle and not bus-off makes `txidle_o` 0 on the next edge.
- R7: `txack_o` is a single-cycle pulse. It is 1 on the edge after `eof7_i` only when the node is in an own frame with no transmit error. `eof7_i` gives no pulse while idle or after a transmit error.
- R8: After an own frame, `txidle_o` stays 0 at `eof7_i`. It returns to 1 on the edge after `imsn3_i` only if `tx_pend_i` is 0; with `tx_pend_i` = 1 it stays 0.
- R9: `arb_lost_i`, `bus_idle_i`, `rx_start_i`, `halt_i` and `sw_reset_i` each set `txidle_o` to 1 on the next edge. This holds only when not bus-off; in bus-off the release strobes leave `txidle_o` at 0.
- R10: `tec_view_o[7:0]` holds `tec_i[7:0]` from the previous cycle, and `tec_view_o[8]` equals `busoff_o`.
- R11: After `tx_err_i` during a frame, `txidle_o` stays 0 until the 3rd intermission bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| tec_i | input | 9 | Transmit error counter |
| rec_i | input | 9 | Receive error counter |
| eof7_i | input | 1 | 7th end-of-frame bit strobe |
| imsn3_i | input | 1 | 3rd intermission bit strobe |
| arb_lost_i | input | 1 | Arbitration lost strobe |
| bus_idle_i | input | 1 | Bus idle strobe |
| rx_start_i | input | 1 | Reception start strobe |
| tx_start_i | input | 1 | Transmission start strobe |
| tx_err_i | input | 1 | Error detected during own transmission |
| halt_i | input | 1 | Halt entry strobe |
| bo_recover_i | input | 1 | Bus-off recovery complete strobe |
| sw_reset_i | input | 1 | Software reset strobe |
| tx_pend_i | input | 1 | Another message is ready to send |
| txidle_o | output | 1 | Not bus-off and no transmission in progress |
| warn_o | output | 1 | Error warning flag |
| busoff_o | output | 1 | Bus-off flag |
| txack_o | output | 1 | Transmit acknowledge pulse |
| tec_view_o | output | 9 | Low 8 counter bits, bit 8 equal to bus-off |

## Verification
The bench sends `eof7_i` in three situations: in a clean frame, after a transmit error, and while idle. A design that acknowledges any end-of-frame would pulse in the last two. It ends a frame with `tx_pend_i` high, where a design that ignores the pending message would wrongly report idle. It also raises `rec_i` past 96 during bus-off; warning logic that is not suppressed would raise `warn_o` there. It sends release strobes during bus-off, where a design that does not gate them would report idle while bus-off. It checks that the bus-off flag stays set after the counter has dropped, and that a 9-bit count whose low byte is not zero shows up correctly in `tec_view_o`.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_XMIT  = 3'd1,
        S_XERR  = 3'd2,
        S_XDONE = 3'd3,
        S_BOFF  = 3'd4
    } tx_state_e;

endpackage

// File: rtl/can_stat_level.sv
module can_stat_level #(
    parameter int CNT_W      = 9,
    parameter int WARN_LIMIT = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  logic             clr_i,
    output logic             bo_next_o,
    output logic             bo_o,
    output logic             warn_o,
    output logic [CNT_W-2:0] tec_low_o
);

    localparam logic [CNT_W-1:0] BO_LIMIT = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] WARN_LVL = CNT_W'(WARN_LIMIT);

    logic bo_q;
    logic warn_q;
    logic warn_next;
    logic tec_warn;
    logic rec_warn;

    // Bus-off is sticky; a clear outranks a high count in the same cycle.
    always_comb begin
        if (clr_i) begin
            bo_next_o = 1'b0;
        end else begin
            bo_next_o = bo_q | (tec_i >= BO_LIMIT);
        end
    end

    always_comb begin
        tec_warn  = (tec_i >= WARN_LVL) && (tec_i < BO_LIMIT);
        rec_warn  = (rec_i >= WARN_LVL) && (rec_i < BO_LIMIT);
        warn_next = !bo_next_o && (tec_warn || rec_warn);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bo_q      <= 1'b0;
            warn_q    <= 1'b0;
            tec_low_o <= '0;
        end else begin
            bo_q      <= bo_next_o;
            warn_q    <= warn_next;
            tec_low_o <= tec_i[CNT_W-2:0];
        end
    end

    assign bo_o   = bo_q;
    assign warn_o = warn_q;

    a_r1_busoff_set: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_i >= BO_LIMIT && !clr_i) |=> bo_q);

    a_r2_busoff_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !bo_q);

    a_r4_warn_quiet_in_bo: assert property (@(posedge clk) disable iff (!rst_n)
        bo_q |-> !warn_q);

endmodule

// File: rtl/can_stat_txseq.sv
module can_stat_txseq
    import can_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bo_next_i,
    input  logic eof7_i,
    input  logic imsn3_i,
    input  logic arb_lost_i,
    input  logic bus_idle_i,
    input  logic rx_start_i,
    input  logic tx_start_i,
    input  logic tx_err_i,
    input  logic halt_i,
    input  logic sw_reset_i,
    input  logic tx_pend_i,
    output logic idle_o,
    output logic ack_o
);

    tx_state_e st_q;
    tx_state_e st_next;
    logic      release_s;
    logic      ack_next;

    assign release_s = arb_lost_i | bus_idle_i | rx_start_i | halt_i;

    // Next-state logic
    always_comb begin
        st_next = st_q;
        if (sw_reset_i) begin
            st_next = S_IDLE;
        end else if (bo_next_i) begin
            st_next = S_BOFF;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (tx_start_i) st_next = S_XMIT;
                end
                S_XMIT: begin
                    if (release_s)     st_next = S_IDLE;
                    else if (tx_err_i) st_next = S_XERR;
                    else if (eof7_i)   st_next = S_XDONE;
                end
                S_XERR, S_XDONE: begin
                    if (release_s)       st_next = S_IDLE;
                    else if (tx_start_i) st_next = S_XMIT;
                    else if (imsn3_i)    st_next = tx_pend_i ? S_XMIT : S_IDLE;
                end
                S_BOFF: begin
                    st_next = S_IDLE;
                end
                default: st_next = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_next;
    end

    assign ack_next = (st_q == S_XMIT) && eof7_i && !tx_err_i && !release_s
                      && !sw_reset_i && !bo_next_i;

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_o <= 1'b1;
            ack_o  <= 1'b0;
        end else begin
            idle_o <= (st_next == S_IDLE);
            ack_o  <= ack_next;
        end
    end

    a_r6_start_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && tx_start_i && !bo_next_i && !sw_reset_i) |=> !idle_o);

    a_r7_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    a_r8_eof_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_XMIT && eof7_i && !tx_err_i && !release_s && !sw_reset_i
         && !bo_next_i) |=> (!idle_o && ack_o));

    a_r9_release_sets_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (release_s && !bo_next_i && st_q != S_IDLE) |=> idle_o);

endmodule

// File: rtl/can_status_flags.sv
module can_status_flags #(
    parameter int CNT_W      = 9,
    parameter int WARN_LIMIT = 96
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tec_i,
    input  logic [CNT_W-1:0] rec_i,
    input  logic             eof7_i,
    input  logic             imsn3_i,
    input  logic             arb_lost_i,
    input  logic             bus_idle_i,
    input  logic             rx_start_i,
    input  logic             tx_start_i,
    input  logic             tx_err_i,
    input  logic             halt_i,
    input  logic             bo_recover_i,
    input  logic             sw_reset_i,
    input  logic             tx_pend_i,
    output logic             txidle_o,
    output logic             warn_o,
    output logic             busoff_o,
    output logic             txack_o,
    output logic [CNT_W-1:0] tec_view_o
);

    logic             bo_next;
    logic             clr;
    logic [CNT_W-2:0] tec_low;

    assign clr = bo_recover_i | sw_reset_i;

    can_stat_level #(
        .CNT_W      (CNT_W),
        .WARN_LIMIT (WARN_LIMIT)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .tec_i     (tec_i),
        .rec_i     (rec_i),
        .clr_i     (clr),
        .bo_next_o (bo_next),
        .bo_o      (busoff_o),
        .warn_o    (warn_o),
        .tec_low_o (tec_low)
    );

    can_stat_txseq u_txseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .bo_next_i  (bo_next),
        .eof7_i     (eof7_i),
        .imsn3_i    (imsn3_i),
        .arb_lost_i (arb_lost_i),
        .bus_idle_i (bus_idle_i),
        .rx_start_i (rx_start_i),
        .tx_start_i (tx_start_i),
        .tx_err_i   (tx_err_i),
        .halt_i     (halt_i),
        .sw_reset_i (sw_reset_i),
        .tx_pend_i  (tx_pend_i),
        .idle_o     (txidle_o),
        .ack_o      (txack_o)
    );

    assign tec_view_o = {busoff_o, tec_low};

    a_r5_idle_not_busoff: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_o |-> !txidle_o);

    a_r10_view_msb: assert property (@(posedge clk) disable iff (!rst_n)
        tec_view_o[CNT_W-1] == busoff_o);

endmodule

// File: tb/can_status_flags_tb.sv
`timescale 1ns/1ps
module can_status_flags_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] tec = '0;
    logic [8:0] rec = '0;
    logic [9:0] st = '0;   // 0 eof7,1 imsn3,2 arb,3 busidle,4 rx,5 txstart,6 halt,7 recover,8 swreset,9 txerr
    logic       pend = 1'b0;
    logic       txidle, warn, busoff, txack;
    logic [8:0] view;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic       idle;
        logic       warn;
        logic       bo;
        logic       ack;
        logic [8:0] view;
        string      tag;
        int         due;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    can_status_flags u_dut (
        .clk(clk), .rst_n(rst_n), .tec_i(tec), .rec_i(rec),
        .eof7_i(st[0]), .imsn3_i(st[1]), .arb_lost_i(st[2]), .bus_idle_i(st[3]),
        .rx_start_i(st[4]), .tx_start_i(st[5]), .halt_i(st[6]),
        .bo_recover_i(st[7]), .sw_reset_i(st[8]), .tx_err_i(st[9]),
        .tx_pend_i(pend), .txidle_o(txidle), .warn_o(warn), .busoff_o(busoff),
        .txack_o(txack), .tec_view_o(view)
    );

    localparam logic [9:0] EOF = 10'h001, IMS = 10'h002, ARB = 10'h004,
                           BID = 10'h008, RXS = 10'h010, TXS = 10'h020,
                           HLT = 10'h040, REC = 10'h080, SWR = 10'h100,
                           TER = 10'h200;

    task automatic drive(input logic [9:0] s, input logic p, input logic [8:0] t,
                         input logic [8:0] r, input logic ei, input logic ew,
                         input logic eb, input logic ea, input string tag);
        exp_t e;
        @(negedge clk);
        st = s; pend = p; tec = t; rec = r;
        e.idle = ei; e.warn = ew; e.bo = eb; e.ack = ea;
        e.view = {eb, t[7:0]}; e.tag = tag; e.due = cyc + 1;
        q.push_back(e);
    endtask

    // Monitor: compare results one edge after the stimulus
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({txidle, warn, busoff, txack, view} !== {e.idle, e.warn, e.bo, e.ack, e.view}) begin
                errors++;
                $display("FAIL %s: got idle=%b warn=%b bo=%b ack=%b view=%h exp idle=%b warn=%b bo=%b ack=%b view=%h",
                         e.tag, txidle, warn, busoff, txack, view,
                         e.idle, e.warn, e.bo, e.ack, e.view);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hang exp finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({txidle, warn, busoff, txack, view} !== {1'b1, 1'b0, 1'b0, 1'b0, 9'h000}) begin
            errors++;
            $display("FAIL R2 R5 reset: got %b%b%b%b %h exp 1000 000", txidle, warn, busoff, txack, view);
        end
        rst_n = 1'b1;
        drive(0, 0, 0, 0, 1, 0, 0, 0, "R5 idle after reset");
        // clean frame
        drive(TXS, 0, 0, 0, 0, 0, 0, 0, "R6 start clears idle");
        drive(0,   0, 0, 0, 0, 0, 0, 0, "R6 busy");
        drive(EOF, 0, 0, 0, 0, 0, 0, 1, "R7 ack at eof7, R8 still busy");
        drive(0,   0, 0, 0, 0, 0, 0, 0, "R7 single pulse");
        drive(IMS, 0, 0, 0, 1, 0, 0, 0, "R8 idle at imsn3");
        // pending message
        drive(TXS, 0, 0, 0, 0, 0, 0, 0, "R6 start");
        drive(EOF, 0, 0, 0, 0, 0, 0, 1, "R7 ack");
        drive(IMS, 1, 0, 0, 0, 0, 0, 0, "R8 pending keeps busy");
        drive(EOF, 0, 0, 0, 0, 0, 0, 1, "R7 ack second frame");
        drive(IMS, 0, 0, 0, 1, 0, 0, 0, "R8 idle nothing pending");
        // transmit error
        drive(TXS, 0, 0, 0, 0, 0, 0, 0, "R6 start");
        drive(TER, 0, 0, 0, 0, 0, 0, 0, "R11 error busy");
        drive(EOF, 0, 0, 0, 0, 0, 0, 0, "R7 no ack after error");
        drive(IMS, 0, 0, 0, 1, 0, 0, 0, "R11 idle at imsn3");
        drive(EOF, 0, 0, 0, 1, 0, 0, 0, "R7 no ack when idle");
        // release strobes
        drive(TXS, 0, 0, 0, 0, 0, 0, 0, "R6 start");
        drive(ARB, 0, 0, 0, 1, 0, 0, 0, "R9 arb lost");
        drive(TXS, 0, 0, 0, 0, 0, 0, 0, "R6 start");
        drive(RXS, 0, 0, 0, 1, 0, 0, 0, "R9 rx start");
        drive(TXS, 0, 0, 0, 0, 0, 0, 0, "R6 start");
        drive(HLT, 0, 0, 0, 1, 0, 0, 0, "R9 halt");
        drive(TXS, 0, 0, 0, 0, 0, 0, 0, "R6 start");
        drive(BID, 0, 0, 0, 1, 0, 0, 0, "R9 bus idle");
        drive(TXS, 0, 0, 0, 0, 0, 0, 0, "R6 start");
        drive(SWR, 0, 0, 0, 1, 0, 0, 0, "R9 sw reset");
        // warning levels
        drive(0, 0, 9'd95,  9'd0,   1, 0, 0, 0, "R3 tec 95");
        drive(0, 0, 9'd96,  9'd0,   1, 1, 0, 0, "R3 tec 96");
        drive(0, 0, 9'd0,   9'd96,  1, 1, 0, 0, "R3 rec 96");
        drive(0, 0, 9'd0,   9'd95,  1, 0, 0, 0, "R3 rec 95");
        drive(0, 0, 9'd255, 9'd0,   1, 1, 0, 0, "R3 R10 tec 255");
        // bus-off
        drive(0, 0, 9'd256, 9'd0,   0, 0, 1, 0, "R1 R4 R5 busoff entry");
        drive(0, 0, 9'd0,   9'd100, 0, 0, 1, 0, "R1 sticky, R4 rec in busoff");
        drive(0, 0, 9'd0,   9'd120, 0, 0, 1, 0, "R4 rec rising");
        drive(ARB, 0, 9'd0, 9'd0,   0, 0, 1, 0, "R9 ignored in busoff");
        drive(TXS, 0, 9'd0, 9'd0,   0, 0, 1, 0, "R5 start in busoff");
        drive(REC, 0, 9'd0, 9'd0,   1, 0, 0, 0, "R2 recovery");
        drive(0, 0, 9'd300, 9'd0,   0, 0, 1, 0, "R10 view 12c");
        drive(SWR, 0, 9'd300, 9'd0, 1, 0, 0, 0, "R2 sw reset beats count");
        drive(0, 0, 9'd128, 9'd0,   1, 1, 0, 0, "R10 view 080");
        drive(0, 0, 9'd0,   9'd0,   1, 0, 0, 0, "R3 both low");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule